// File: doc/BRIEF.md
# Nested Loop Buffer Controller

This controller sits on the instruction-memory side of a split fetch path. The CPU keeps a small tagless loop buffer of its own. Each cycle the controller sends the CPU a 2-bit indication that picks one of four actions: fetch from memory, fetch from memory and also write into the buffer, replay from the buffer in order, or jump to a buffer slot given on the content bus. It finds loops from taken backward branches. It keeps a short stack of loop entries, so an inner loop can be captured and replayed inside an outer loop that is still being captured.

Each cycle models one fetched instruction at `fetch_addr`. When that instruction is a backward branch, its outcome is reported in the same cycle on `bb_valid` and `bb_taken`. A misprediction pulse from the CPU cancels all loop tracking. The memory disable output goes high in every cycle in which the CPU reads from its buffer. Every output is registered, so a decision made from the inputs of one cycle appears after the next rising clock edge.

Top module: `loop_buf_ctrl`

## Requirements
- R1: A synchronous active-low reset sets `ind` to 00, `buf_index` to 0, `mem_off` to 0, and empties the loop stack and the buffer write slot.
- R2: `ind` encodes 00 = fetch from memory, 01 = fetch and write into the buffer (fill), 10 = replay from the buffer in order (active), 11 = take a buffer slot from the content bus (index). `mem_off` is 1 exactly when `ind` is 10 or 11.
- R3: A taken backward branch whose address is not on top of the stack is pushed with its fill bit clear, and the next indication is 01.
- R4: A taken backward branch that matches the top entry while filling, active or indexing sets that entry's fill bit. The next indication is 11 with `buf_index` equal to the entry's first buffer slot, and the indication after that is 10 unless a new event occurs.
- R5: Every fill cycle uses one buffer slot. A loop pushed onto an empty stack starts at slot 0. A nested loop starts at the next free slot.
- R6: A not-taken backward branch that matches the top entry pops it. If an entry remains and its fill bit is clear, the next indication is 01. Otherwise it is 00.
- R7: A misprediction pulse empties the stack and makes the next indication 00. It takes priority over any branch event in the same cycle.
- R8: A fill cycle that arrives after all 64 buffer slots are used makes the next indication 00 and empties the stack.
- R9: A push onto a full 4-entry stack is ignored and the next indication is 00. A taken branch that matches the top entry while at 00 leaves the indication at 00.
- R10: `buf_index` is 0 whenever `ind` is not 11.
- R11: A not-taken backward branch that does not match the top entry, or a cycle with no branch, leaves the indication unchanged, except that 11 always moves on to 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | ADDR_W | Address of the instruction fetched this cycle |
| bb_valid | input | 1 | The instruction is a backward branch resolved this cycle |
| bb_taken | input | 1 | Outcome of that backward branch |
| mispredict | input | 1 | Branch misprediction pulse from the CPU |
| ind | output | 2 | Loop indication sent to the CPU |
| buf_index | output | log2(BUF_DEPTH) | Buffer slot sent over the content bus in index cycles |
| mem_off | output | 1 | Instruction memory disable |

## Verification
Two events can fall in the same cycle: a misprediction pulse and the loop-closing branch of the top entry. The first asks for a flush, the second for a jump into the buffer. The bench drives both in one cycle during a fill. It expects 00 on the next cycle. It then sends a not-taken branch at that loop's address and expects 00 again, which shows that the stack was emptied and that the matching branch did not take effect. A second case of this kind is a pop that happens while the controller is still indexing, where the bench checks that the fill bit of the parent entry alone decides between 01 and 00.

// File: rtl/lbc_pkg.sv
// Shared types for the loop buffer controller.
// Assumes nothing beyond a 2-bit indication to the CPU.
package lbc_pkg;
    // The encoding is visible at the CPU pins and must not change
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FILL   = 2'b01,
        ST_ACTIVE = 2'b10,
        ST_INDEX  = 2'b11
    } lbc_state_t;
endpackage

// File: rtl/lbc_stack.sv
// Loop stack: one entry per loop being tracked, holding the branch
// address, the fill bit and the first buffer slot of the loop.
// Assumes the caller never asks for pop on an empty stack. A push onto
// a full stack is dropped. Priority: flush, pop, push, set_fill.
module lbc_stack #(
    parameter int ADDR_W    = 32,
    parameter int SLOT_W    = 6,
    parameter int STK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              pop,
    input  logic              push,
    input  logic              set_fill,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [SLOT_W-1:0] push_base,
    output logic [ADDR_W-1:0] top_addr,
    output logic [SLOT_W-1:0] top_base,
    output logic              below_fill,
    output logic              multi,
    output logic              empty,
    output logic              full
);
    localparam int CW = $clog2(STK_DEPTH + 1);

    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q [STK_DEPTH];
    logic [SLOT_W-1:0] base_q [STK_DEPTH];
    logic [STK_DEPTH-1:0] fill_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(STK_DEPTH));
    assign multi = (cnt_q > CW'(1));

    // Track the entry count
    always_ff @(posedge clk) begin
        if (!rst_n || flush)      cnt_q <= '0;
        else if (pop && !empty)   cnt_q <= cnt_q - CW'(1);
        else if (push && !full)   cnt_q <= cnt_q + CW'(1);
    end

    // Write the entry fields
    always_ff @(posedge clk) begin
        for (int i = 0; i < STK_DEPTH; i++) begin
            if (!rst_n || flush) begin
                addr_q[i] <= '0;
                base_q[i] <= '0;
                fill_q[i] <= 1'b0;
            end else if (pop) begin
                fill_q[i] <= fill_q[i];
            end else if (push && !full && cnt_q == CW'(i)) begin
                addr_q[i] <= push_addr;
                base_q[i] <= push_base;
                fill_q[i] <= 1'b0;
            end else if (set_fill && cnt_q == CW'(i + 1)) begin
                fill_q[i] <= 1'b1;
            end
        end
    end

    // Read the top entry and the fill bit of the entry below it
    always_comb begin
        top_addr   = '0;
        top_base   = '0;
        below_fill = 1'b0;
        for (int i = 0; i < STK_DEPTH; i++) begin
            if (cnt_q == CW'(i + 1)) begin
                top_addr = addr_q[i];
                top_base = base_q[i];
            end
            if (cnt_q == CW'(i + 2)) below_fill = fill_q[i];
        end
    end

    // R9
    push_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);
    // R6
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && !empty) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/lbc_next.sv
// Next-state decision for the loop buffer controller. Purely
// combinational. It works out the indication, the write slot, the index
// and the stack commands from one cycle of branch information.
// Assumes that a branch is resolved in the same cycle it is fetched.
module lbc_next
    import lbc_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int SLOT_W    = 6
) (
    input  lbc_state_t        state,
    input  logic [SLOT_W:0]   wptr,
    input  logic              bb_valid,
    input  logic              bb_taken,
    input  logic              mispredict,
    input  logic              match,
    input  logic              empty,
    input  logic              full,
    input  logic              multi,
    input  logic              below_fill,
    input  logic [SLOT_W-1:0] top_base,
    output lbc_state_t        state_n,
    output logic [SLOT_W:0]   wptr_n,
    output logic [SLOT_W-1:0] idx_n,
    output logic              push,
    output logic              pop,
    output logic              set_fill,
    output logic              flush
);
    logic storing;
    assign storing = (state == ST_FILL);

    // Choose the next state and the stack command
    always_comb begin
        state_n  = state;
        wptr_n   = wptr;
        idx_n    = '0;
        push     = 1'b0;
        pop      = 1'b0;
        set_fill = 1'b0;
        flush    = 1'b0;
        if (mispredict) begin
            flush   = 1'b1;
            state_n = ST_IDLE;
        end else if (storing && wptr == (SLOT_W+1)'(BUF_DEPTH)) begin
            flush   = 1'b1;
            state_n = ST_IDLE;
        end else begin
            if (storing) wptr_n = wptr + (SLOT_W+1)'(1);
            if (state == ST_INDEX) state_n = ST_ACTIVE;
            if (bb_valid && bb_taken && match) begin
                if (state != ST_IDLE) begin
                    set_fill = 1'b1;
                    state_n  = ST_INDEX;
                    idx_n    = top_base;
                end else begin
                    state_n = ST_IDLE;
                end
            end else if (bb_valid && bb_taken) begin
                if (full) begin
                    state_n = ST_IDLE;
                end else begin
                    push    = 1'b1;
                    state_n = ST_FILL;
                    if (empty) wptr_n = '0;
                end
            end else if (bb_valid && match) begin
                pop     = 1'b1;
                state_n = (multi && !below_fill) ? ST_FILL : ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/loop_buf_ctrl.sv
// Memory-side controller for a CPU-side tagless loop buffer.
// It holds the indication state, the next free buffer slot and the
// index sent in jump cycles. The loop stack and the decision logic
// are separate modules below it.
// Assumes one instruction per cycle, with the branch outcome known in
// the fetch cycle.
module loop_buf_ctrl
    import lbc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUF_DEPTH = 64,
    parameter int STK_DEPTH = 4,
    localparam int SLOT_W   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              bb_valid,
    input  logic              bb_taken,
    input  logic              mispredict,
    output logic [1:0]        ind,
    output logic [SLOT_W-1:0] buf_index,
    output logic              mem_off
);
    lbc_state_t        state_q, state_n;
    logic [SLOT_W:0]   wptr_q, wptr_n;
    logic [SLOT_W-1:0] idx_q, idx_n;
    logic              push, pop, set_fill, flush;
    logic [ADDR_W-1:0] top_addr;
    logic [SLOT_W-1:0] top_base;
    logic              below_fill, multi, empty, full, match;

    assign match = !empty && (fetch_addr == top_addr);

    lbc_stack #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .STK_DEPTH(STK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pop(pop), .push(push),
        .set_fill(set_fill), .push_addr(fetch_addr), .push_base(wptr_n[SLOT_W-1:0]),
        .top_addr(top_addr), .top_base(top_base), .below_fill(below_fill),
        .multi(multi), .empty(empty), .full(full)
    );

    lbc_next #(.BUF_DEPTH(BUF_DEPTH), .SLOT_W(SLOT_W)) u_next (
        .state(state_q), .wptr(wptr_q), .bb_valid(bb_valid), .bb_taken(bb_taken),
        .mispredict(mispredict), .match(match), .empty(empty), .full(full),
        .multi(multi), .below_fill(below_fill), .top_base(top_base),
        .state_n(state_n), .wptr_n(wptr_n), .idx_n(idx_n), .push(push),
        .pop(pop), .set_fill(set_fill), .flush(flush)
    );

    // Register the state, the write slot and the index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wptr_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            wptr_q  <= wptr_n;
            idx_q   <= idx_n;
        end
    end

    assign ind       = state_q;
    assign buf_index = idx_q;
    assign mem_off   = state_q[1];

    // R7
    mispredict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> (ind == 2'b00));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && !mispredict && wptr_q == (SLOT_W+1)'(BUF_DEPTH))
        |=> (state_q == ST_IDLE));
    // R4
    index_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INDEX && !mispredict && !bb_valid) |=> (state_q == ST_ACTIVE));
    // R5
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_q <= (SLOT_W+1)'(BUF_DEPTH));
    // R10
    index_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_n != ST_INDEX) |=> (buf_index == '0));
endmodule

// File: tb/loop_buf_ctrl_test.sv
module loop_buf_ctrl_test;
    localparam int N = 32;
    // {addr[31:0], bb_valid, bb_taken, mispredict, exp_ind[1:0], exp_idx[5:0]}
    localparam logic [42:0] VEC [N] = '{
        {32'h00, 3'b000, 2'b00, 6'd0},  // 0  R11 idle stays
        {32'h40, 3'b110, 2'b01, 6'd0},  // 1  R3 push
        {32'h00, 3'b000, 2'b01, 6'd0},  // 2
        {32'h00, 3'b000, 2'b01, 6'd0},  // 3
        {32'h00, 3'b000, 2'b01, 6'd0},  // 4
        {32'h40, 3'b110, 2'b11, 6'd0},  // 5  R4 trigger
        {32'h00, 3'b000, 2'b10, 6'd0},  // 6
        {32'h40, 3'b110, 2'b11, 6'd0},  // 7
        {32'h40, 3'b100, 2'b00, 6'd0},  // 8  R6 exit
        {32'h80, 3'b110, 2'b01, 6'd0},  // 9  outer push
        {32'h00, 3'b000, 2'b01, 6'd0},  // 10
        {32'h00, 3'b000, 2'b01, 6'd0},  // 11
        {32'h60, 3'b110, 2'b01, 6'd0},  // 12 R5 nested push at slot 3
        {32'h00, 3'b000, 2'b01, 6'd0},  // 13
        {32'h60, 3'b110, 2'b11, 6'd3},  // 14
        {32'h00, 3'b000, 2'b10, 6'd0},  // 15
        {32'h60, 3'b100, 2'b01, 6'd0},  // 16 parent unfilled
        {32'h00, 3'b000, 2'b01, 6'd0},  // 17
        {32'h80, 3'b110, 2'b11, 6'd0},  // 18
        {32'h80, 3'b100, 2'b00, 6'd0},  // 19
        {32'h90, 3'b110, 2'b01, 6'd0},  // 20
        {32'h00, 3'b001, 2'b00, 6'd0},  // 21 R7
        {32'h90, 3'b100, 2'b00, 6'd0},  // 22 stack flushed
        {32'hA0, 3'b110, 2'b01, 6'd0},  // 23
        {32'hA0, 3'b110, 2'b11, 6'd0},  // 24
        {32'hB0, 3'b110, 2'b01, 6'd0},  // 25 push while indexing
        {32'hB0, 3'b110, 2'b11, 6'd1},  // 26
        {32'hB0, 3'b100, 2'b00, 6'd0},  // 27 parent filled
        {32'hA0, 3'b100, 2'b00, 6'd0},  // 28
        {32'hC0, 3'b110, 2'b01, 6'd0},  // 29
        {32'hC0, 3'b111, 2'b00, 6'd0},  // 30 R7 same cycle as trigger
        {32'hC0, 3'b100, 2'b00, 6'd0}   // 31
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        bb_valid = 1'b0, bb_taken = 1'b0, mispredict = 1'b0;
    logic [1:0]  ind;
    logic [5:0]  buf_index;
    logic        mem_off;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    loop_buf_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .bb_valid(bb_valid),
        .bb_taken(bb_taken), .mispredict(mispredict), .ind(ind),
        .buf_index(buf_index), .mem_off(mem_off)
    );

    function automatic string req_of(int i);
        if (i <= 8)  return "R4";
        if (i <= 19) return "R5";
        if (i <= 22) return "R7";
        if (i <= 28) return "R6";
        return "R7";
    endfunction

    task automatic step(input logic [31:0] a, input logic v, input logic t, input logic m);
        @(negedge clk);
        fetch_addr = a; bb_valid = v; bb_taken = t; mispredict = m;
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [1:0] ei, input logic [5:0] ex);
        checks++;
        if (ind !== ei || buf_index !== ex || mem_off !== ei[1]) begin
            errors++;
            $display("FAIL %s: ind=%b idx=%0d off=%b expected ind=%b idx=%0d off=%b",
                     req, ind, buf_index, mem_off, ei, ex, ei[1]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #5;
        chk("R1", 2'b00, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R10: table walk, mem_off and buf_index are checked on every row
        for (int i = 0; i < N; i++) begin
            step(VEC[i][42:11], VEC[i][10], VEC[i][9], VEC[i][8]);
            chk(req_of(i), VEC[i][7:6], VEC[i][5:0]);
        end

        // R8: buffer overflow while filling
        step(32'h10, 1, 1, 0);
        chk("R3", 2'b01, 6'd0);
        for (int k = 0; k < 64; k++) step(32'h0, 0, 0, 0);
        chk("R8", 2'b01, 6'd0);
        step(32'h0, 0, 0, 0);
        chk("R8", 2'b00, 6'd0);
        step(32'h10, 1, 1, 0);      // stack was emptied, so this pushes again
        chk("R8", 2'b01, 6'd0);
        step(32'h0, 0, 0, 1);
        chk("R7", 2'b00, 6'd0);

        // R9: full stack
        for (int k = 0; k < 4; k++) begin
            step(32'h100 + k, 1, 1, 0);
            chk("R3", 2'b01, 6'd0);
        end
        step(32'h104, 1, 1, 0);
        chk("R9", 2'b00, 6'd0);
        step(32'h103, 1, 1, 0);
        chk("R9", 2'b00, 6'd0);
        step(32'h103, 1, 0, 0);     // parent 0x102 unfilled, 0x104 never stored
        chk("R9", 2'b01, 6'd0);
        step(32'h777, 1, 0, 0);
        chk("R11", 2'b01, 6'd0);
        step(32'h0, 0, 0, 1);
        chk("R7", 2'b00, 6'd0);

        // R1: reset in the middle of a fill
        step(32'h200, 1, 1, 0);
        chk("R3", 2'b01, 6'd0);
        @(negedge clk);
        rst_n = 1'b0; bb_valid = 1'b0;
        @(posedge clk);
        #5;
        chk("R1", 2'b00, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(32'h200, 1, 0, 0);
        chk("R1", 2'b00, 6'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule